// File: doc/BRIEF.md
# Chip-Rate Timing Controller with Antenna Sync

This block produces the timing hierarchy that a W-CDMA path searcher runs on. It also governs the single write port through which antenna samples arrive, time-interleaved. The core clock runs at `OVERSAMPLE * CYCLES` times the chip rate. Each sample period holds `CYCLES` clock cycles, and cycle `k` of that period belongs to antenna `k`. The counts are:

- cycle within sample
- sample within chip
- chip within slot, with the bit and window split derived from it
- slot within frame
- a frame parity bit

The counters advance only when the antenna write handshake allows it. Writes that arrive early are throttled, a late antenna stalls the whole hierarchy, and after reset the block waits for a sample flagged as the frame reference.

Each accepted sample leaves the block at once with its antenna index and its I/Q halves separated. Registered one-cycle strobes tell downstream stages when a new window, slot or frame has begun.

Top module: `chip_timing_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `sync_irq` is 1, `wr_accept` is 1, every count and strobe is 0 and `smp_valid` is 0.
- R2: While `sync_irq` is 1, a write without `wr_sync` is accepted and discarded: `smp_valid` stays 0, every count stays 0 and `sync_irq` stays 1.
- R3: A write with `wr_sync` set while `sync_irq` is 1 is accepted as antenna 0, chip 0, slot 0, frame parity 0, and is output as a sample. From the next cycle on, `sync_irq` is 0.
- R4: While running, `wr_accept` is 1 only when the cycle count is below `ANTENNAS`. A write presented in a later cycle waits, unaccepted, until the cycle count returns to 0.
- R5: While running, a cycle whose cycle count is below `ANTENNAS` and that has no write leaves every count unchanged.
- R6: Cycles with a cycle count of `ANTENNAS` or more advance the counts with no write present.
- R7: For an accepted sample, `smp_valid` is 1 in the same cycle. `smp_ant` equals the cycle count, `smp_q` is `wr_data[15:8]` and `smp_i` is `wr_data[7:0]`, both two's complement.
- R8: The cycle count wraps after `CYCLES-1` and then increments the sample count. The sample count wraps after `OVERSAMPLE-1` and then increments the chip count. The chip count wraps after 2559 and then increments the slot count. `bit_cnt` is the chip count divided by 256, and `win_cnt` is the chip count modulo 256 divided by `WINDOW`.
- R9: Frame parity toggles when slot 14 wraps to slot 0.
- R10: `win_stb`, `slot_stb` and `frame_stb` are 1 for exactly the one cycle after the counts enter a new window, slot or frame respectively, the sync sample included. A slot strobe always comes with a window strobe, and a frame strobe always comes with both.
- R11: `wr_sync` on a write while running has no effect on the counts, the strobes or `sync_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, `OVERSAMPLE*CYCLES` times the chip rate |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Antenna write strobe |
| wr_data | input | 16 | Sample, Q in 15:8 and I in 7:0 |
| wr_sync | input | 1 | Marks the sample as the frame reference |
| wr_accept | output | 1 | Write accepted this cycle |
| sync_irq | output | 1 | Waiting for a frame-reference sample |
| cyc_cnt | output | CW | Cycle within sample |
| samp_cnt | output | SW | Sample within chip |
| chip_cnt | output | 12 | Chip within slot |
| bit_cnt | output | 4 | Bit within slot |
| win_cnt | output | WW | Window within bit |
| slot_cnt | output | 4 | Slot within frame |
| frame_par | output | 1 | Frame parity |
| win_stb | output | 1 | New window started |
| slot_stb | output | 1 | New slot started |
| frame_stb | output | 1 | New frame started |
| smp_valid | output | 1 | Qualified sample present |
| smp_ant | output | CW | Antenna index of the sample |
| smp_i | output | 8 | In-phase part, signed |
| smp_q | output | 8 | Quadrature part, signed |

## Verification
A boundary crossing can coincide with a starved antenna. The bench stops writing at the end of chip 399 and again at the end of the slot. The free cycles then carry the counts into the new chip or slot, and the counts must hold at cycle 0 with exactly one strobe, while the scoreboard expects no sample. A second coincidence is a frame-reference flag riding on an ordinary accepted write while running. That write must still reach the scoreboard with its data, and the same cycle must leave `sync_irq`, `frame_stb` and the slot count untouched.

// File: rtl/chip_timing_ctrl.sv
module chip_timing_ctrl #(
  parameter int OVERSAMPLE = 2,
  parameter int CYCLES     = 4,
  parameter int ANTENNAS   = 2,
  parameter int WINDOW     = 64,
  localparam int CW   = (CYCLES > 1) ? $clog2(CYCLES) : 1,
  localparam int SW   = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1,
  localparam int WLOG = $clog2(WINDOW),
  localparam int WPB  = 256 / WINDOW,
  localparam int WW   = (WPB > 1) ? $clog2(WPB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [15:0]       wr_data,
  input  logic              wr_sync,
  output logic              wr_accept,
  output logic              sync_irq,
  output logic [CW-1:0]     cyc_cnt,
  output logic [SW-1:0]     samp_cnt,
  output logic [11:0]       chip_cnt,
  output logic [3:0]        bit_cnt,
  output logic [WW-1:0]     win_cnt,
  output logic [3:0]        slot_cnt,
  output logic              frame_par,
  output logic              win_stb,
  output logic              slot_stb,
  output logic              frame_stb,
  output logic              smp_valid,
  output logic [CW-1:0]     smp_ant,
  output logic signed [7:0] smp_i,
  output logic signed [7:0] smp_q
);
  localparam int SLOT_CHIPS = 2560;
  localparam int SLOTS      = 15;

  logic waiting;
  logic ant_cyc, sync_evt, adv;
  logic cyc_last, samp_last, chip_last, slot_last;
  logic chip_end, win_end, slot_end, frame_end;

  assign ant_cyc   = 32'(cyc_cnt) < ANTENNAS;
  assign sync_evt  = waiting & wr_valid & wr_sync;
  assign adv       = waiting ? sync_evt : (~ant_cyc | wr_valid);
  assign cyc_last  = 32'(cyc_cnt) == CYCLES - 1;
  assign samp_last = 32'(samp_cnt) == OVERSAMPLE - 1;
  assign chip_last = 32'(chip_cnt) == SLOT_CHIPS - 1;
  assign slot_last = 32'(slot_cnt) == SLOTS - 1;
  assign chip_end  = adv & cyc_last & samp_last;
  assign win_end   = chip_end & (&chip_cnt[WLOG-1:0]);
  assign slot_end  = chip_end & chip_last;
  assign frame_end = slot_end & slot_last;

  assign sync_irq  = waiting;
  assign wr_accept = waiting | ant_cyc;
  assign smp_valid = wr_valid & wr_accept & (~waiting | wr_sync);
  assign smp_ant   = cyc_cnt;
  assign smp_i     = wr_data[7:0];
  assign smp_q     = wr_data[15:8];
  assign bit_cnt   = chip_cnt[11:8];
  assign win_cnt   = WW'(chip_cnt[7:0] >> WLOG);

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting   <= 1'b1;
      cyc_cnt   <= '0;
      samp_cnt  <= '0;
      chip_cnt  <= '0;
      slot_cnt  <= '0;
      frame_par <= 1'b0;
      win_stb   <= 1'b0;
      slot_stb  <= 1'b0;
      frame_stb <= 1'b0;
    end else begin
      if (sync_evt) waiting <= 1'b0;
      if (adv) cyc_cnt <= cyc_last ? '0 : cyc_cnt + 1'b1;
      if (adv && cyc_last) samp_cnt <= samp_last ? '0 : samp_cnt + 1'b1;
      if (chip_end) chip_cnt <= chip_last ? '0 : chip_cnt + 1'b1;
      if (slot_end) slot_cnt <= slot_last ? '0 : slot_cnt + 1'b1;
      if (frame_end) frame_par <= ~frame_par;
      win_stb   <= sync_evt | win_end;
      slot_stb  <= sync_evt | slot_end;
      frame_stb <= sync_evt | frame_end;
    end
  end

  a_r2_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (waiting && !(wr_valid && wr_sync)) |=> (sync_irq && chip_cnt == 0 && cyc_cnt == 0));

  a_r3_sync_starts: assert property (@(posedge clk) disable iff (rst)
    (waiting && wr_valid && wr_sync) |=> (!sync_irq && win_stb && slot_stb && frame_stb
                                          && slot_cnt == 0 && !frame_par));

  a_r5_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (!waiting && ant_cyc && !wr_valid) |=> ($stable(cyc_cnt) && $stable(samp_cnt)
                                            && $stable(chip_cnt) && $stable(slot_cnt)));

  a_r6_free_moves: assert property (@(posedge clk) disable iff (rst)
    (!waiting && !ant_cyc) |=> (cyc_cnt != $past(cyc_cnt)));

  a_r9_parity_at_frame: assert property (@(posedge clk) disable iff (rst)
    (frame_par != $past(frame_par)) |-> frame_stb);

  a_r10_nesting: assert property (@(posedge clk) disable iff (rst)
    (frame_stb |-> slot_stb) and (slot_stb |-> win_stb));

  a_r10_single: assert property (@(posedge clk) disable iff (rst)
    win_stb |=> !win_stb);

  a_r11_no_resync: assert property (@(posedge clk) disable iff (rst)
    !waiting |=> !sync_irq);
endmodule

// File: tb/test_chip_timing_ctrl.sv
`timescale 1ns/100ps
module test_chip_timing_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  int n_tests = 0, n_fail = 0;
  bit reported = 0;

  logic wr_valid = 0, wr_sync = 0;
  logic [15:0] wr_data = '0;
  logic wr_accept, sync_irq, frame_par, win_stb, slot_stb, frame_stb, smp_valid;
  logic [1:0] cyc_cnt, smp_ant;
  logic [0:0] samp_cnt;
  logic [11:0] chip_cnt;
  logic [3:0] bit_cnt, slot_cnt;
  logic [1:0] win_cnt;
  logic signed [7:0] smp_i, smp_q;

  chip_timing_ctrl i_chip_timing_ctrl (
    .clk, .rst, .wr_valid, .wr_data, .wr_sync, .wr_accept, .sync_irq,
    .cyc_cnt, .samp_cnt, .chip_cnt, .bit_cnt, .win_cnt, .slot_cnt, .frame_par,
    .win_stb, .slot_stb, .frame_stb, .smp_valid, .smp_ant, .smp_i, .smp_q);

  logic f_valid = 0, f_sync = 0;
  logic f_accept, f_irq, f_par, f_wstb, f_sstb, f_fstb, f_svalid;
  logic [0:0] f_cyc, f_samp, f_ant;
  logic [11:0] f_chip;
  logic [3:0] f_bit, f_slot;
  logic [5:0] f_win;
  logic signed [7:0] f_i, f_q;

  chip_timing_ctrl #(.OVERSAMPLE(1), .CYCLES(1), .ANTENNAS(1), .WINDOW(4)) i_chip_timing_ctrl_fast (
    .clk, .rst, .wr_valid(f_valid), .wr_data(16'h1234), .wr_sync(f_sync),
    .wr_accept(f_accept), .sync_irq(f_irq), .cyc_cnt(f_cyc), .samp_cnt(f_samp),
    .chip_cnt(f_chip), .bit_cnt(f_bit), .win_cnt(f_win), .slot_cnt(f_slot),
    .frame_par(f_par), .win_stb(f_wstb), .slot_stb(f_sstb), .frame_stb(f_fstb),
    .smp_valid(f_svalid), .smp_ant(f_ant), .smp_i(f_i), .smp_q(f_q));

  logic [31:0] sb[$];
  int n_win = 0, n_slot = 0, n_frame = 0, f_frames = 0;
  bit f_done = 0;
  int seq = 0;

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (win_stb) n_win++;
      if (slot_stb) n_slot++;
      if (frame_stb) n_frame++;
      if (f_fstb) f_frames++;
    end
  end

  always @(negedge clk) begin
    logic [31:0] e;
    if (!rst && smp_valid) begin
      if (sb.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R7: unexpected sample got ant %0d expected none", smp_ant);
      end else begin
        e = sb.pop_front();
        check("R7 antenna", int'(smp_ant), int'(e[31:24]));
        check("R7 q", int'(smp_q), int'($signed(e[23:16])));
        check("R7 i", int'(smp_i), int'($signed(e[15:8])));
      end
    end
  end

  task automatic put(input int ant, input logic [7:0] i, input logic [7:0] q,
                     input bit sync, input bit push, output int waits);
    waits = 0;
    if (push) sb.push_back({8'(ant), q, i, 8'h00});
    wr_valid = 1; wr_data = {q, i}; wr_sync = sync;
    @(negedge clk);
    while (!wr_accept) begin waits++; @(negedge clk); end
    @(posedge clk); #1;
    wr_valid = 0; wr_sync = 0;
  endtask

  task automatic run_chips(input int n);
    int w;
    for (int c = 0; c < n; c++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 2; a++) begin
          seq++;
          put(a, 8'(seq * 5), 8'(8'h80 + seq * 3), 0, 1, w);
        end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq in reset", int'(sync_irq), 1);
    #1 rst = 0;
    @(negedge clk);
    check("R1 irq", int'(sync_irq), 1);
    check("R1 accept", int'(wr_accept), 1);
    check("R1 chip", int'(chip_cnt), 0);
    check("R1 strobes", int'({win_stb, slot_stb, frame_stb}), 0);
    check("R1 valid", int'(smp_valid), 0);
    @(posedge clk); #1;
    put(0, 8'h11, 8'h22, 0, 0, w);
    @(negedge clk);
    check("R2 irq stays", int'(sync_irq), 1);
    check("R2 cycle stays", int'(cyc_cnt), 0);
    check("R2 chip stays", int'(chip_cnt), 0);
    @(posedge clk); #1;
    put(0, 8'hF0, 8'h7F, 1, 1, w);
    @(negedge clk);
    check("R3 irq cleared", int'(sync_irq), 0);
    check("R3 cycle after sync", int'(cyc_cnt), 1);
    check("R3 slot", int'(slot_cnt), 0);
    check("R3 parity", int'(frame_par), 0);
    check("R10 strobes at sync", int'({win_stb, slot_stb, frame_stb}), 7);
    @(posedge clk); #1;
    @(negedge clk);
    check("R5 stall cycle", int'(cyc_cnt), 1);
    check("R10 strobe one cycle", int'(win_stb), 0);
    @(posedge clk); #1;
    put(1, 8'h81, 8'h05, 1, 1, w);
    @(negedge clk);
    check("R11 irq stays low", int'(sync_irq), 0);
    check("R11 no frame strobe", int'(frame_stb), 0);
    check("R11 slot", int'(slot_cnt), 0);
    check("R6 free cycle reached", int'(cyc_cnt), 2);
    @(posedge clk); #1;
    put(0, 8'h40, 8'hC0, 0, 1, w);
    check("R4 early write waits", w, 1);
    @(negedge clk);
    check("R8 sample count", int'(samp_cnt), 1);
    check("R8 cycle wrap", int'(cyc_cnt), 1);
    check("R8 chip", int'(chip_cnt), 0);
    @(posedge clk); #1;
    put(1, 8'h01, 8'hFF, 0, 1, w);
    run_chips(399);
    repeat (3) @(negedge clk);
    check("R8 chip 400", int'(chip_cnt), 400);
    check("R8 bit", int'(bit_cnt), 1);
    check("R8 window", int'(win_cnt), 2);
    check("R8 samp", int'(samp_cnt), 0);
    repeat (4) @(negedge clk);
    check("R5 stall holds chip", int'(chip_cnt), 400);
    check("R5 stall holds cycle", int'(cyc_cnt), 0);
    @(posedge clk); #1;
    run_chips(2160);
    repeat (3) @(negedge clk);
    check("R8 slot advance", int'(slot_cnt), 1);
    check("R8 chip wrap", int'(chip_cnt), 0);
    check("R10 slot strobe", int'(slot_stb), 1);
    @(negedge clk); #1;
    check("R10 window strobes", n_win, 41);
    check("R10 slot strobes", n_slot, 2);
    check("R10 frame strobes", n_frame, 1);
    check("R7 scoreboard drained", sb.size(), 0);
    wait (f_done);
    report();
  end

  initial begin
    @(negedge rst);
    @(posedge clk); #1;
    f_valid = 1; f_sync = 1;
    @(posedge clk); #1;
    f_sync = 0;
    repeat (2559) @(posedge clk);
    #1 f_valid = 0;
    @(negedge clk);
    check("R8 fast slot", int'(f_slot), 1);
    check("R8 fast chip", int'(f_chip), 0);
    check("R10 fast slot strobe", int'(f_sstb), 1);
    repeat (3) @(negedge clk);
    check("R5 fast stall", int'(f_chip), 0);
    @(posedge clk); #1;
    f_valid = 1;
    repeat (35840) @(posedge clk);
    #1;
    @(negedge clk);
    check("R9 parity toggles", int'(f_par), 1);
    check("R9 slot wrap", int'(f_slot), 0);
    check("R9 frame strobe", int'(f_fstb), 1);
    #1;
    check("R9 frame strobe count", f_frames, 2);
    f_done = 1;
  end
endmodule